// File: doc/BRIEF.md
# Display Driver Serial Command Decoder

This block is the host-facing serial slave of a vacuum-fluorescent display controller. The host drives three wires: a strobe that frames each transfer, a shift clock, and a data line. A separate line, `sdo_out`, returns data to the host. All three inputs are asynchronous to the fast system clock, so they are resynchronised and their edges are found in the system clock domain.

Bytes arrive least significant bit first, one bit on each rising shift-clock edge taken while the strobe is low. The first complete byte after the strobe falls is a command, and its two top bits pick one of four classes:

- Grid mode selects the number of grids.
- Data setting selects write, key-read or one-shot reset, together with the address step and a test flag.
- Address loads the display RAM address.
- Display control sets dimming, display on and the output driver type.

Every later byte in the same frame is display data. It is written to a 48-location RAM port at the current address, and the address steps forward unless stepping is disabled. In key-read mode the block instead shifts four key bytes out on `sdo_out`, changing on the falling shift-clock edges.

The grid scanner, the key capture logic and the RAM itself sit outside this block. The scanner takes the configuration outputs. The key logic presents its bytes on `key_bits`. The RAM takes the write strobe.

Top module: `dsi_top`

## Requirements
- R1: After reset the block holds these values: `grid_count` = 16 (mode code 1111), `dim_code` = 000, `disp_on` = 0, `scan_en` = 0, `test_mode` = 0, `sdo_oe` = 0 (open-drain, idle), and no RAM write is issued.
- R2: Each byte is assembled LSB first from the data line, sampled at rising shift-clock edges taken while the strobe is low. The first byte of a frame is a command, and its bits 7:6 select the class: 00 grid mode, 01 data setting, 10 display control, 11 address.
- R3: A display control command loads `dim_code` from bits 2:0 and `disp_on` from bit 3. It also sets `scan_en` to 1.
- R4: A grid mode command carries its code in bits 3:0; bits 5:4 are don't care. A code different from the current one is loaded and forces `disp_on` and `scan_en` to 0. A code equal to the current one leaves every output unchanged.
- R5: With data setting bits 1:0 = 00 and bit 2 = 0, each data byte produces a one-cycle `ram_we` with `ram_addr` equal to the current address and `ram_wdata` equal to the byte. The address then increments by one.
- R6: With data setting bit 2 = 1, successive data bytes are all written to the same address.
- R7: An address command loads bits 5:0. When the current address is 30h or more, whether it was loaded or reached by incrementing past 2Fh, data bytes produce no write until a valid address is loaded.
- R8: The shift clock is ignored while the strobe is high. A strobe rise in the middle of a byte discards the partial byte, and the next frame starts with a fresh command byte.
- R9: A data setting command with bits 1:0 = 10 enters key-read mode. On each falling shift-clock edge after that command, `sdo_out` presents the next bit of `key_bits`, starting at bit 0. The sequence wraps to bit 0 after bit 31, and data bytes clocked in this mode write nothing. While the strobe is high, `sdo_out` is 1.
- R10: Display control bits 5:4 = 10 selects push-pull, where `sdo_oe` is always 1. Any other value selects open-drain, where `sdo_oe` equals the inverse of `sdo_out`.
- R11: A data setting command with bits 1:0 = 01 produces exactly one one-cycle `soft_rst` pulse. `test_mode` follows bit 3 of the latest data setting command.
- R12: `grid_count` is 8 for mode code 0000 and 9 + code[2:0] when code[3] = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| strobe_in | input | 1 | Frame strobe, active low, asynchronous |
| sdata_in | input | 1 | Serial data input, asynchronous |
| key_bits | input | 32 | Four key bytes, bit 0 is shifted out first |
| sdo_out | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the data output pad |
| ram_we | output | 1 | One-cycle display RAM write strobe |
| ram_addr | output | 6 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| grid_count | output | 5 | Number of grids selected by the mode code |
| dim_code | output | 3 | Dimming code |
| disp_on | output | 1 | Display enable |
| scan_en | output | 1 | Key scan enable |
| test_mode | output | 1 | Test flag from the data setting command |
| soft_rst | output | 1 | One-cycle reset request pulse |

## Verification
Each pin change reaches the synchronised copy after two system clocks, and the edge detector acts on the third. Bit shifts and `sdo_out` updates therefore land three clocks after the pin edge. Configuration registers and `ram_we` follow one clock after the eighth rising edge is consumed, four clocks after that pin edge. The bench holds each shift-clock level for eight system clocks and reads `sdo_out` at the end of the low half, well after its three-clock update. It reads configuration 32 clocks after the strobe rises, so every result is sampled after it is due and before the next stimulus. RAM writes and reset pulses are counted by a monitor at the clock edge, so a missing pulse or an extra pulse shows up as a wrong count.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_DATA = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_ADDR = 2'b11
  } cmd_class_e;

  // grids driven for a mode code: 0xxx -> 8, 1xxx -> 9 + xxx
  function automatic logic [4:0] grids_of(input logic [3:0] code);
    return code[3] ? (5'd9 + {2'b00, code[2:0]}) : 5'd8;
  endfunction

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a, input int depth);
    return int'(a) < depth;
  endfunction

  function automatic logic pushpull_sel(input logic [1:0] f);
    return f == 2'b10;
  endfunction
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], async_in[i]};
    end
    assign sync_out[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/dsi_shifter.sv
module dsi_shifter #(
  parameter int BW = dsi_pkg::BYTE_W,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          stb_s,
  input  logic          din_s,
  output logic          sclk_fall,
  output logic          byte_valid,
  output logic          byte_first,
  output logic [BW-1:0] byte_data
);
  logic          sclk_d;
  logic          sclk_rise;
  logic [CW-1:0] bit_cnt;
  logic [BW-1:0] shreg;
  logic          first;
  logic [BW-1:0] next_shreg;

  assign sclk_rise  = sclk_s & ~sclk_d & ~stb_s;
  assign sclk_fall  = ~sclk_s & sclk_d & ~stb_s;
  assign next_shreg = {din_s, shreg[BW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      first      <= 1'b1;
      byte_valid <= 1'b0;
      byte_first <= 1'b0;
      byte_data  <= '0;
    end else begin
      sclk_d     <= sclk_s;
      byte_valid <= 1'b0;
      if (stb_s) begin
        bit_cnt <= '0;
        first   <= 1'b1;
      end else if (sclk_rise) begin
        shreg   <= next_shreg;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(BW - 1)) begin
          byte_valid <= 1'b1;
          byte_data  <= next_shreg;
          byte_first <= first;
          first      <= 1'b0;
        end
      end
    end
  end

  // R8
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> (bit_cnt == '0));
  // R2
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
endmodule

// File: rtl/dsi_regs.sv
module dsi_regs #(
  parameter int RAM_DEPTH = 48,
  localparam int AW = dsi_pkg::ADDR_W,
  localparam int BW = dsi_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic          byte_first,
  input  logic [BW-1:0] byte_data,
  output logic [3:0]    mode_code,
  output logic [2:0]    dim_code,
  output logic          disp_on,
  output logic          scan_en,
  output logic          pushpull,
  output logic [3:0]    data_set,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [BW-1:0] ram_wdata,
  output logic          soft_rst,
  output logic          rd_start
);
  import dsi_pkg::*;

  logic [AW-1:0] addr;
  cmd_class_e    cls;
  logic          is_cmd;
  logic          is_data;

  assign cls     = cmd_class_e'(byte_data[7:6]);
  assign is_cmd  = byte_valid & byte_first;
  assign is_data = byte_valid & ~byte_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_code <= 4'b1111;
      dim_code  <= '0;
      disp_on   <= 1'b0;
      scan_en   <= 1'b0;
      pushpull  <= 1'b0;
      data_set  <= '0;
      addr      <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      soft_rst  <= 1'b0;
      rd_start  <= 1'b0;
    end else begin
      ram_we   <= 1'b0;
      soft_rst <= 1'b0;
      rd_start <= 1'b0;
      if (is_cmd) begin
        case (cls)
          CLS_MODE: if (byte_data[3:0] != mode_code) begin
            mode_code <= byte_data[3:0];
            disp_on   <= 1'b0;
            scan_en   <= 1'b0;
          end
          CLS_DATA: begin
            data_set <= byte_data[3:0];
            soft_rst <= (byte_data[1:0] == 2'b01);
            rd_start <= (byte_data[1:0] == 2'b10);
          end
          CLS_ADDR: addr <= byte_data[AW-1:0];
          CLS_CTRL: begin
            dim_code <= byte_data[2:0];
            disp_on  <= byte_data[3];
            scan_en  <= 1'b1;
            pushpull <= pushpull_sel(byte_data[5:4]);
          end
          default: ;
        endcase
      end else if (is_data && data_set[1:0] == 2'b00 && addr_ok(addr, RAM_DEPTH)) begin
        ram_we    <= 1'b1;
        ram_addr  <= addr;
        ram_wdata <= byte_data;
        if (!data_set[2]) addr <= addr + 1'b1;
      end
    end
  end

  // R4
  mode_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != $past(mode_code)) |-> (!disp_on && !scan_en));
  // R7
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (int'(ram_addr) < RAM_DEPTH));
  // R5
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !data_set[2]) |-> (addr == AW'(ram_addr + 1'b1)));
  // R6
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && data_set[2]) |-> (addr == ram_addr));
endmodule

// File: rtl/dsi_keyout.sv
module dsi_keyout #(
  parameter int KEY_BITS = 32,
  localparam int IW = $clog2(KEY_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_fall,
  input  logic                stb_s,
  input  logic                rd_start,
  input  logic                pushpull,
  input  logic [KEY_BITS-1:0] key_bits,
  output logic                sdo,
  output logic                sdo_oe
);
  logic          rd_active;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      idx       <= '0;
      sdo       <= 1'b1;
    end else if (stb_s) begin
      rd_active <= 1'b0;
      idx       <= '0;
      sdo       <= 1'b1;
    end else if (rd_start) begin
      rd_active <= 1'b1;
      idx       <= '0;
    end else if (rd_active && sclk_fall) begin
      sdo <= key_bits[idx];
      idx <= (idx == IW'(KEY_BITS - 1)) ? '0 : idx + 1'b1;
    end
  end

  assign sdo_oe = pushpull | ~sdo;

  // R9
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> $past(sclk_fall || stb_s));
  // R9
  sdo_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> sdo);
endmodule

// File: rtl/dsi_top.sv
module dsi_top #(
  parameter int RAM_DEPTH   = 48,
  parameter int KEY_BYTES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int KEY_BITS = KEY_BYTES * dsi_pkg::BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclk_in,
  input  logic                        strobe_in,
  input  logic                        sdata_in,
  input  logic [KEY_BITS-1:0]         key_bits,
  output logic                        sdo_out,
  output logic                        sdo_oe,
  output logic                        ram_we,
  output logic [dsi_pkg::ADDR_W-1:0]  ram_addr,
  output logic [dsi_pkg::BYTE_W-1:0]  ram_wdata,
  output logic [4:0]                  grid_count,
  output logic [2:0]                  dim_code,
  output logic                        disp_on,
  output logic                        scan_en,
  output logic                        test_mode,
  output logic                        soft_rst
);
  logic [2:0] pins_s;
  logic       sclk_fall, byte_valid, byte_first, pushpull, rd_start;
  logic [dsi_pkg::BYTE_W-1:0] byte_data;
  logic [3:0] mode_code, data_set;

  dsi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({sdata_in, strobe_in, sclk_in}), .sync_out(pins_s));

  dsi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[0]), .stb_s(pins_s[1]),
    .din_s(pins_s[2]), .sclk_fall(sclk_fall), .byte_valid(byte_valid),
    .byte_first(byte_first), .byte_data(byte_data));

  dsi_regs #(.RAM_DEPTH(RAM_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
    .byte_data(byte_data), .mode_code(mode_code), .dim_code(dim_code),
    .disp_on(disp_on), .scan_en(scan_en), .pushpull(pushpull),
    .data_set(data_set), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .soft_rst(soft_rst), .rd_start(rd_start));

  dsi_keyout #(.KEY_BITS(KEY_BITS)) u_key (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .stb_s(pins_s[1]),
    .rd_start(rd_start), .pushpull(pushpull), .key_bits(key_bits),
    .sdo(sdo_out), .sdo_oe(sdo_oe));

  assign grid_count = dsi_pkg::grids_of(mode_code);
  assign test_mode  = data_set[3];

  // R11
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  // R10
  drive_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe) |-> sdo_out);
endmodule

// File: tb/dsi_top_test.sv
`timescale 1ns/1ps
module dsi_top_test;
  localparam int H = 8;
  localparam logic [31:0] KEYS = 32'hA5C3_1E69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, stb = 1'b1, sdin = 1'b1;
  logic sdo_out, sdo_oe, ram_we, disp_on, scan_en, test_mode, soft_rst;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [4:0] grid_count;
  logic [2:0] dim_code;

  int total = 0, bad = 0, wr_cnt = 0, rst_cnt = 0;
  logic [5:0] wa [64];
  logic [7:0] wd [64];
  bit done = 0;

  always #2.5 clk = ~clk;

  dsi_top uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .strobe_in(stb), .sdata_in(sdin),
    .key_bits(KEYS), .sdo_out(sdo_out), .sdo_oe(sdo_oe), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .grid_count(grid_count),
    .dim_code(dim_code), .disp_on(disp_on), .scan_en(scan_en),
    .test_mode(test_mode), .soft_rst(soft_rst));

  always @(posedge clk) begin
    if (ram_we) begin
      wa[wr_cnt % 64] <= ram_addr;
      wd[wr_cnt % 64] <= ram_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (soft_rst) rst_cnt <= rst_cnt + 1;
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b);
    sclk = 1'b0; sdin = b; wt(H);
    sclk = 1'b1; wt(H);
  endtask

  task automatic sbyte(logic [7:0] v);
    for (int i = 0; i < 8; i++) sbit(v[i]);
  endtask

  task automatic fbeg; stb = 1'b0; wt(H); endtask
  task automatic fend; wt(H); stb = 1'b1; wt(4 * H); endtask
  task automatic cmd1(logic [7:0] v); fbeg(); sbyte(v); fend(); endtask

  task automatic t_reset;
    chk("R1 grid_count", 32'(grid_count), 32'd16);
    chk("R1 dim_code", 32'(dim_code), 32'd0);
    chk("R1 disp_on/scan_en", {30'd0, disp_on, scan_en}, 32'd0);
    chk("R1 test_mode", 32'(test_mode), 32'd0);
    chk("R1 sdo_oe", 32'(sdo_oe), 32'd0);
    chk("R1 no write", 32'(wr_cnt), 32'd0);
  endtask

  task automatic t_ctrl;
    cmd1(8'h8B);
    chk("R3 dim", 32'(dim_code), 32'd3);
    chk("R3 on/scan", {30'd0, disp_on, scan_en}, 32'd3);
    chk("R2 mode unchanged", 32'(grid_count), 32'd16);
    cmd1(8'hA5);
    chk("R3 dim5 off", {28'd0, dim_code, disp_on}, {28'd0, 3'd5, 1'b0});
    chk("R10 push-pull oe", 32'(sdo_oe), 32'd1);
    cmd1(8'hB8);
    chk("R10 field 11 open-drain", 32'(sdo_oe), 32'd0);
    cmd1(8'hA8);
    cmd1(8'h98);
    chk("R10 field 01 open-drain", 32'(sdo_oe), 32'd0);
    chk("R3 on", 32'(disp_on), 32'd1);
  endtask

  task automatic t_mode;
    cmd1(8'h0F);
    chk("R4 same code keeps on", {30'd0, disp_on, scan_en}, 32'd3);
    cmd1(8'h00);
    chk("R12 code 0000 gives 8", 32'(grid_count), 32'd8);
    chk("R4 new code forces off", {30'd0, disp_on, scan_en}, 32'd0);
    cmd1(8'h0A);
    chk("R12 code 1010 gives 11", 32'(grid_count), 32'd11);
    cmd1(8'h8F);
    cmd1(8'h3A);
    chk("R4 same code, b5:b4 ignored", {27'd0, grid_count, disp_on, scan_en},
        {27'd0, 5'd11, 2'b11});
  endtask

  task automatic t_write;
    int base;
    cmd1(8'h40);
    base = wr_cnt;
    fbeg(); sbyte(8'hC0); sbyte(8'h11); sbyte(8'h22); sbyte(8'h33); fend();
    chk("R5 write count", 32'(wr_cnt - base), 32'd3);
    for (int i = 0; i < 3; i++)
      chk("R5 addr/data", {18'd0, wa[(base + i) % 64], wd[(base + i) % 64]},
          {18'd0, 6'(i), 8'(8'h11 * (i + 1))});
  endtask

  task automatic t_fixed;
    int base;
    cmd1(8'h44);
    base = wr_cnt;
    fbeg(); sbyte(8'hC5); sbyte(8'hAA); sbyte(8'hBB); fend();
    chk("R6 write count", 32'(wr_cnt - base), 32'd2);
    chk("R6 first", {18'd0, wa[base % 64], wd[base % 64]}, {18'd0, 6'h05, 8'hAA});
    chk("R6 second", {18'd0, wa[(base + 1) % 64], wd[(base + 1) % 64]}, {18'd0, 6'h05, 8'hBB});
  endtask

  task automatic t_range;
    int base;
    cmd1(8'h40);
    base = wr_cnt;
    fbeg(); sbyte(8'hEE); sbyte(8'h01); sbyte(8'h02); sbyte(8'h03); fend();
    chk("R7 stops past 2Fh", 32'(wr_cnt - base), 32'd2);
    chk("R7 last addr", 32'(wa[(base + 1) % 64]), 32'h2F);
    base = wr_cnt;
    fbeg(); sbyte(8'hF0); sbyte(8'h09); fend();
    chk("R7 30h dropped", 32'(wr_cnt - base), 32'd0);
    fbeg(); sbyte(8'hC1); sbyte(8'h07); fend();
    chk("R7 valid resumes", {24'd0, 2'b0, wa[base % 64]}, 32'h01);
    chk("R7 valid count", 32'(wr_cnt - base), 32'd1);
  endtask

  task automatic t_abort;
    int base;
    cmd1(8'h88);
    fbeg();
    for (int i = 0; i < 4; i++) sbit(1'b1);
    stb = 1'b1; wt(4 * H);
    sbyte(8'h8F);
    wt(4 * H);
    chk("R8 partial and idle clocks ignored", {28'd0, dim_code, disp_on}, {28'd0, 3'd0, 1'b1});
    cmd1(8'h8D);
    chk("R8 fresh command", {28'd0, dim_code, disp_on}, {28'd0, 3'd5, 1'b1});
    base = wr_cnt;
    fbeg(); sbyte(8'hC8);
    for (int i = 0; i < 3; i++) sbit(1'b0);
    stb = 1'b1; wt(4 * H);
    chk("R8 partial data dropped", 32'(wr_cnt - base), 32'd0);
  endtask

  task automatic t_read;
    int base;
    base = wr_cnt;
    fbeg(); sbyte(8'h42); wt(4 * H);
    for (int i = 0; i < 40; i++) begin
      sclk = 1'b0; sdin = 1'b1; wt(H);
      chk("R9 R10 key bit and oe", {30'd0, sdo_oe, sdo_out},
          {30'd0, ~KEYS[i % 32], KEYS[i % 32]});
      sclk = 1'b1; wt(H);
    end
    fend();
    chk("R9 idle high", 32'(sdo_out), 32'd1);
    chk("R9 no write in read mode", 32'(wr_cnt - base), 32'd0);
    cmd1(8'h40);
  endtask

  task automatic t_misc;
    int r0;
    r0 = rst_cnt;
    cmd1(8'h49);
    chk("R11 one pulse", 32'(rst_cnt - r0), 32'd1);
    chk("R11 test flag", 32'(test_mode), 32'd1);
    cmd1(8'h40);
    chk("R11 test cleared", 32'(test_mode), 32'd0);
    chk("R11 no extra pulse", 32'(rst_cnt - r0), 32'd1);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(10);
    t_reset();
    t_ctrl();
    t_mode();
    t_write();
    t_fixed();
    t_range();
    t_abort();
    t_read();
    t_misc();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule